// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This peripheral keeps time as a plain 32-bit count of seconds. A reloadable prescaler divides the clock by a programmable amount and produces one tick per second, and each tick adds one to the seconds counter. A 32-bit alarm value is compared against the counter. A match raises an alarm flag, and a tick raises a tick flag. Each flag has its own interrupt enable, and the two requests are merged onto a single interrupt line.

Software reaches the block over a single-cycle register bus. Reads are answered in the same cycle. Writes are guarded twice. First, a key word written to the unlock register opens a one-shot write window. Second, a ready bit in the control register must read 1 before the write is issued. Each accepted write closes the window and holds the ready bit low for a fixed settling period. The event flags clear when 0 is written to them and stay as they are when 1 is written, so a read-modify-write of the control register never loses a pending event. A general-purpose scratch word is also provided.

Top module: `sec_rtc`

## Requirements
- R1: After reset, control reads 0x80 (only ready set), the seconds, alarm, scratch and unlock registers read 0, the reload register reads 32767, and irq is 0.
- R2: Registers sit at byte offsets control 0x00, seconds 0x04, alarm 0x08, reload 0x0C, scratch 0x34 and unlock 0x3C. A read of any other offset returns 0, and rdata is 0 when no read is selected.
- R3: Writing 0x0000A55A to the unlock register sets its bit 31. Writing any other value clears it. A write to any other offset is ignored while bit 31 is clear.
- R4: Control bit 7 (ready) reads 0 for exactly 3 cycles after an accepted write. Any write issued while ready is 0, including a write to the unlock register, is ignored.
- R5: Bit 31 of the unlock register clears after one accepted write, so a second write without a new key is ignored.
- R6: While control bit 0 (run) is 1, a tick occurs every reload+1 cycles. Writing the reload register restarts the prescaler count from zero.
- R7: Each tick adds 1 to the seconds counter, and 0xFFFFFFFF wraps to 0. An accepted write to the seconds register loads the written value.
- R8: While run is 0, the prescaler and the seconds counter hold their values.
- R9: A tick sets control bit 6 (tick flag). The cycle after the seconds counter equals the alarm register while control bit 2 (alarm enable) is 1, control bit 4 (alarm flag) is set. Setting takes priority over a clearing write in the same cycle.
- R10: Writing 0 to bit 6 or bit 4 of the control register clears that flag. Writing 1 leaves it unchanged and never sets it. Bits 5, 3, 2 and 0 take the written value. Bit 1 reads 0.
- R11: irq is 1 exactly when (tick flag and bit 5) or (alarm flag and bit 3) holds.
- R12: The scratch register stores and returns a full 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; it also drives the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq | output | 1 | Combined interrupt request |

## Verification
The counter is run with a short reload so that ticks come quickly. The spacing between seconds changes tells a correct reload+1 period apart from an off-by-one. A start near 0xFFFFFFFF shows that the counter wraps. Writes are tried in four conditions: without a key, with a wrong key, inside the busy window, and twice after a single key. Each one shows whether the lock and the ready handshake gate writes separately. Flag writes with 0 and with 1, issued before and after an alarm match and a tick, show clear-on-zero behaviour apart from set-on-write, and show which interrupt source drives irq.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SECS    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ALARM   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_RELOAD  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_SCRATCH = 6'h34;
    localparam logic [ADDR_W-1:0] OFS_UNLOCK  = 6'h3C;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A55A;

    localparam int CB_RUN   = 0;
    localparam int CB_AEN   = 2;
    localparam int CB_AIE   = 3;
    localparam int CB_AFLAG = 4;
    localparam int CB_TIE   = 5;
    localparam int CB_TFLAG = 6;
    localparam int CB_READY = 7;
    localparam int WEN_BIT  = 31;

    typedef enum logic [2:0] {
        RS_NONE, RS_CTRL, RS_SECS, RS_ALARM, RS_RELOAD, RS_SCRATCH, RS_UNLOCK
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic alm_en;
        logic alm_ie;
        logic tick_ie;
    } ctrl_cfg_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL:    return RS_CTRL;
            OFS_SECS:    return RS_SECS;
            OFS_ALARM:   return RS_ALARM;
            OFS_RELOAD:  return RS_RELOAD;
            OFS_SCRATCH: return RS_SCRATCH;
            OFS_UNLOCK:  return RS_UNLOCK;
            default:     return RS_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_cfg_t c, input logic tflag,
                                                    input logic aflag, input logic rdy);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CB_RUN]   = c.run;
        v[CB_AEN]   = c.alm_en;
        v[CB_AIE]   = c.alm_ie;
        v[CB_AFLAG] = aflag;
        v[CB_TIE]   = c.tick_ie;
        v[CB_TFLAG] = tflag;
        v[CB_READY] = rdy;
        return v;
    endfunction
endpackage

// File: rtl/sec_rtc_prescale.sv
module sec_rtc_prescale #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               restart,
    input  logic [PRESC_W-1:0] reload,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt_q;

    assign tick = run && (cnt_q == reload);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (run)       cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end

    assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(cnt_q));
    assert_restart_zero_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/sec_rtc_wgate.sv
module sec_rtc_wgate #(
    parameter int  BUSY_CYCLES = 3,
    parameter bit  UNLOCK_EN   = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_req,
    input  logic                            to_unlock,
    input  logic [sec_rtc_pkg::DATA_W-1:0]  wdata,
    output logic                            accept,
    output logic                            ready,
    output logic                            wen
);
    import sec_rtc_pkg::*;
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [BW-1:0] busy_q;
    logic          open;

    assign ready  = (busy_q == '0);
    assign accept = wr_req && ready && !to_unlock && open;

    always_ff @(posedge clk) begin
        if (rst)         busy_q <= '0;
        else if (accept) busy_q <= BW'(BUSY_CYCLES);
        else if (!ready) busy_q <= busy_q - 1'b1;
    end

    generate
        if (UNLOCK_EN) begin : g_lock
            logic wen_q;
            always_ff @(posedge clk) begin
                if (rst)                               wen_q <= 1'b0;
                else if (wr_req && ready && to_unlock) wen_q <= (wdata == UNLOCK_KEY);
                else if (accept)                       wen_q <= 1'b0;
            end
            assign open = wen_q;
            assign wen  = wen_q;

            assert_wen_oneshot_R5: assert property (@(posedge clk) disable iff (rst)
                accept |=> !wen);
            assert_locked_blocks_R3: assert property (@(posedge clk) disable iff (rst)
                (wr_req && !to_unlock && !wen) |-> !accept);
        end else begin : g_open
            assign open = 1'b1;
            assign wen  = 1'b0;
        end
    endgenerate

    assert_busy_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);
endmodule

// File: rtl/sec_rtc_events.sv
module sec_rtc_events (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic alm_hit,
    input  logic ctrl_wr,
    input  logic keep_tflag,
    input  logic keep_aflag,
    input  logic tick_ie,
    input  logic alm_ie,
    output logic tick_flag,
    output logic alm_flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_flag <= 1'b0;
            alm_flag  <= 1'b0;
        end else begin
            if (tick)         tick_flag <= 1'b1;
            else if (ctrl_wr) tick_flag <= tick_flag & keep_tflag;
            if (alm_hit)      alm_flag  <= 1'b1;
            else if (ctrl_wr) alm_flag  <= alm_flag & keep_aflag;
        end
    end

    assign irq = (tick_flag & tick_ie) | (alm_flag & alm_ie);

    assert_alarm_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(alm_flag) |-> $past(alm_hit));
    assert_tick_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(tick_flag) |-> $past(tick));
    assert_flag_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (alm_flag && !(ctrl_wr && !keep_aflag)) |=> alm_flag);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
    parameter int PRESC_W     = 16,
    parameter int RELOAD_RST  = 32767,
    parameter int BUSY_CYCLES = 3,
    parameter bit UNLOCK_EN   = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_sel,
    input  logic                             bus_wr,
    input  logic [sec_rtc_pkg::ADDR_W-1:0]   bus_addr,
    input  logic [sec_rtc_pkg::DATA_W-1:0]   bus_wdata,
    output logic [sec_rtc_pkg::DATA_W-1:0]   bus_rdata,
    output logic                             irq
);
    import sec_rtc_pkg::*;

    reg_sel_e           rsel;
    logic               wr_req, accept, ready, wen, tick, alm_hit;
    logic               tick_flag, alm_flag;
    logic [DATA_W-1:0]  secs_q, alarm_q, scratch_q;
    logic [PRESC_W-1:0] reload_q;
    ctrl_cfg_t          cfg_q;
    logic               wr_ctrl, wr_secs, wr_alarm, wr_reload, wr_scratch;

    assign rsel       = decode_addr(bus_addr);
    assign wr_req     = bus_sel && bus_wr;
    assign wr_ctrl    = accept && (rsel == RS_CTRL);
    assign wr_secs    = accept && (rsel == RS_SECS);
    assign wr_alarm   = accept && (rsel == RS_ALARM);
    assign wr_reload  = accept && (rsel == RS_RELOAD);
    assign wr_scratch = accept && (rsel == RS_SCRATCH);

    sec_rtc_wgate #(.BUSY_CYCLES(BUSY_CYCLES), .UNLOCK_EN(UNLOCK_EN)) u_gate (
        .clk(clk), .rst(rst), .wr_req(wr_req), .to_unlock(rsel == RS_UNLOCK),
        .wdata(bus_wdata), .accept(accept), .ready(ready), .wen(wen));

    sec_rtc_prescale #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst(rst), .run(cfg_q.run), .restart(wr_reload),
        .reload(reload_q), .tick(tick));

    assign alm_hit = cfg_q.alm_en && (secs_q == alarm_q);

    sec_rtc_events u_evt (
        .clk(clk), .rst(rst), .tick(tick), .alm_hit(alm_hit), .ctrl_wr(wr_ctrl),
        .keep_tflag(bus_wdata[CB_TFLAG]), .keep_aflag(bus_wdata[CB_AFLAG]),
        .tick_ie(cfg_q.tick_ie), .alm_ie(cfg_q.alm_ie),
        .tick_flag(tick_flag), .alm_flag(alm_flag), .irq(irq));

    always_ff @(posedge clk) begin
        if (rst) begin
            secs_q    <= '0;
            alarm_q   <= '0;
            scratch_q <= '0;
            reload_q  <= PRESC_W'(RELOAD_RST);
            cfg_q     <= '0;
        end else begin
            if (wr_secs)         secs_q <= bus_wdata;
            else if (tick)       secs_q <= secs_q + 1'b1;
            if (wr_alarm)        alarm_q   <= bus_wdata;
            if (wr_scratch)      scratch_q <= bus_wdata;
            if (wr_reload)       reload_q  <= bus_wdata[PRESC_W-1:0];
            if (wr_ctrl) begin
                cfg_q.run     <= bus_wdata[CB_RUN];
                cfg_q.alm_en  <= bus_wdata[CB_AEN];
                cfg_q.alm_ie  <= bus_wdata[CB_AIE];
                cfg_q.tick_ie <= bus_wdata[CB_TIE];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (rsel)
                RS_CTRL:    bus_rdata = pack_ctrl(cfg_q, tick_flag, alm_flag, ready);
                RS_SECS:    bus_rdata = secs_q;
                RS_ALARM:   bus_rdata = alarm_q;
                RS_RELOAD:  bus_rdata = DATA_W'(reload_q);
                RS_SCRATCH: bus_rdata = scratch_q;
                RS_UNLOCK:  bus_rdata = DATA_W'(wen) << WEN_BIT;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assert_secs_step_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_secs) |=> (secs_q == $past(secs_q) + 32'd1));
    assert_secs_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.run && !wr_secs) |=> $stable(secs_q));
    assert_idle_bus_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/tb_sec_rtc.sv
module tb_sec_rtc;
    import sec_rtc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sec_rtc dut (.clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
                 .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    // behavioural reference model
    logic [31:0] m_secs, m_alarm, m_scr;
    int          m_reload, m_pcnt, m_busy;
    bit          m_wen, m_run, m_aen, m_aie, m_tie, m_tf, m_af;

    function automatic logic [31:0] m_read(input logic [5:0] a);
        logic [31:0] v = 0;
        case (a)
            6'h00: begin
                v[0] = m_run; v[2] = m_aen; v[3] = m_aie; v[4] = m_af;
                v[5] = m_tie; v[6] = m_tf;  v[7] = (m_busy == 0);
            end
            6'h04: v = m_secs;
            6'h08: v = m_alarm;
            6'h0C: v = m_reload;
            6'h34: v = m_scr;
            6'h3C: v = {m_wen, 31'd0};
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h00: return "R10";
            6'h04: return "R7";
            6'h08: return "R2";
            6'h0C: return "R6";
            6'h34: return "R12";
            6'h3C: return "R3";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_secs = 0; m_alarm = 0; m_scr = 0; m_reload = 32767; m_pcnt = 0; m_busy = 0;
            m_wen = 0; m_run = 0; m_aen = 0; m_aie = 0; m_tie = 0; m_tf = 0; m_af = 0;
        end else begin
            bit rdy, acc, tk, hit;
            rdy = (m_busy == 0);
            acc = bus_sel && bus_wr && rdy && bus_addr != 6'h3C && m_wen;
            tk  = m_run && (m_pcnt == m_reload);
            hit = m_aen && (m_secs == m_alarm);
            if (bus_sel && bus_wr && rdy && bus_addr == 6'h3C) m_wen = (bus_wdata == 32'h0000A55A);
            else if (acc) m_wen = 0;
            if (acc && bus_addr == 6'h0C) m_pcnt = 0;
            else if (m_run) m_pcnt = tk ? 0 : m_pcnt + 1;
            m_busy = acc ? 3 : (m_busy > 0 ? m_busy - 1 : 0);
            if (acc && bus_addr == 6'h04) m_secs = bus_wdata;
            else if (tk) m_secs = m_secs + 1;
            if (tk) m_tf = 1; else if (acc && bus_addr == 6'h00) m_tf = m_tf && bus_wdata[6];
            if (hit) m_af = 1; else if (acc && bus_addr == 6'h00) m_af = m_af && bus_wdata[4];
            if (acc && bus_addr == 6'h00) begin
                m_run = bus_wdata[0]; m_aen = bus_wdata[2]; m_aie = bus_wdata[3]; m_tie = bus_wdata[5];
            end
            if (acc && bus_addr == 6'h08) m_alarm = bus_wdata;
            if (acc && bus_addr == 6'h0C) m_reload = bus_wdata[15:0];
            if (acc && bus_addr == 6'h34) m_scr = bus_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R11 irq", {31'd0, irq}, {31'd0, (m_tf && m_tie) || (m_af && m_aie)});
            if (bus_sel && !bus_wr) chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
        end
    end

    task automatic rd(input logic [5:0] a, input logic [31:0] mask, input logic [31:0] exp,
                      input string tag);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata & mask, exp);
    endtask

    task automatic rd_val(input logic [5:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            bus_sel = 1; bus_wr = 0; bus_addr = 6'h00;
            @(negedge clk);
            if (bus_rdata[7]) break;
        end
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic sec_write(input logic [5:0] a, input logic [31:0] d);
        bus_write(6'h3C, 32'h0000A55A);
        bus_write(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 150000 && !done) begin
                n_run++; n_fail++;
                $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] v, prev;
        int c1, c2;
        idle(4);
        #1 rst = 0;

        // R1 reset state
        rd(6'h00, 32'hFFFF_FFFF, 32'h80, "R1 ctrl");
        rd(6'h0C, 32'hFFFF_FFFF, 32'd32767, "R1 reload");
        rd(6'h04, 32'hFFFF_FFFF, 32'h0, "R1 secs");
        rd(6'h3C, 32'hFFFF_FFFF, 32'h0, "R1 unlock");
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(6'h10, 32'hFFFF_FFFF, 32'h0, "R2 unmapped");

        // R3 locked write ignored, wrong key
        bus_write(6'h04, 32'h55);
        rd(6'h04, 32'hFFFF_FFFF, 32'h0, "R3 locked write");
        rd(6'h00, 32'h80, 32'h80, "R3 ready untouched");
        bus_write(6'h3C, 32'h1234);
        rd(6'h3C, 32'hFFFF_FFFF, 32'h0, "R3 wrong key");
        bus_write(6'h3C, 32'h0000A55A);
        rd(6'h3C, 32'hFFFF_FFFF, 32'h8000_0000, "R3 key sets bit31");

        // R4 ready window, R5 one-shot, R12 scratch
        bus_write(6'h34, 32'hDEAD_BEEF);
        bus_sel = 1; bus_wr = 0; bus_addr = 6'h00;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R4 ready window", {31'd0, bus_rdata[7]}, {31'd0, (i == 3)});
            @(posedge clk); #1;
        end
        rd(6'h3C, 32'hFFFF_FFFF, 32'h0, "R5 wen cleared");
        rd(6'h34, 32'hFFFF_FFFF, 32'hDEAD_BEEF, "R12 scratch");
        bus_write(6'h34, 32'h1111_2222);
        rd(6'h34, 32'hFFFF_FFFF, 32'hDEAD_BEEF, "R5 second write ignored");

        // R4 unlock write during busy ignored
        sec_write(6'h08, 32'd103);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'h3C; bus_wdata = 32'h0000A55A;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
        idle(4);
        rd(6'h3C, 32'hFFFF_FFFF, 32'h0, "R4 busy unlock ignored");
        rd(6'h08, 32'hFFFF_FFFF, 32'd103, "R2 alarm readback");

        // R6 period with reload 4
        sec_write(6'h0C, 32'd4);
        rd(6'h0C, 32'hFFFF_FFFF, 32'd4, "R6 reload readback");
        sec_write(6'h04, 32'd10);
        sec_write(6'h00, 32'h1);
        rd_val(6'h04, prev); c1 = -1; c2 = -1;
        for (int i = 0; i < 30 && c2 < 0; i++) begin
            rd_val(6'h04, v);
            if (v != prev) begin
                if (c1 < 0) c1 = i; else c2 = i;
            end
            prev = v;
        end
        chk("R6 tick period", c2 - c1, 32'd5);

        // R8 hold when stopped
        sec_write(6'h00, 32'h0);
        rd_val(6'h04, v);
        idle(20);
        rd(6'h04, 32'hFFFF_FFFF, v, "R8 seconds hold");

        // R7 wrap
        sec_write(6'h04, 32'hFFFF_FFFF);
        sec_write(6'h00, 32'h1);
        prev = 32'hFFFF_FFFF;
        for (int i = 0; i < 12; i++) begin
            rd_val(6'h04, v);
            if (v != prev) break;
        end
        chk("R7 wrap", v, 32'h0);

        // R9 alarm, R11 irq
        sec_write(6'h04, 32'd100);
        sec_write(6'h00, 32'h0D);
        idle(40);
        rd(6'h00, 32'h10, 32'h10, "R9 alarm flag");
        chk("R11 alarm irq", {31'd0, irq}, 32'd1);

        // R10 clear with 0, write 1 does not set
        sec_write(6'h00, 32'h0D);
        rd(6'h00, 32'h10, 32'h0, "R10 flag cleared");
        chk("R11 irq dropped", {31'd0, irq}, 32'd0);
        sec_write(6'h00, 32'h1D);
        rd(6'h00, 32'h10, 32'h0, "R10 write one no set");

        // R9 tick flag, R11 tick irq, R10 keep with 1
        sec_write(6'h00, 32'h21);
        idle(10);
        rd(6'h00, 32'h40, 32'h40, "R9 tick flag");
        chk("R11 tick irq", {31'd0, irq}, 32'd1);
        sec_write(6'h00, 32'h61);
        rd(6'h00, 32'h40, 32'h40, "R10 flag kept");
        rd(6'h00, 32'h02, 32'h0, "R10 bit1 zero");

        idle(10);
        bus_sel = 0;
        idle(2);
        finish_run();
    end
endmodule